// File: doc/BRIEF.md
# Cylinder Head Stepping Controller

This block runs a cylinder-mode disk operation. It starts from a given head, verifies that head's address once, and then moves through the remaining tracks of the cylinder. The record addresses of the later tracks are not reprocessed. A head counter spans heads 0 to 39. It is loaded from the start head when an operation begins and is advanced by one at every end of track. After each advance the new head is selected with a strobe that waits for the unit-select and squelch conditions.

The operation ends normally in one of two ways. The first is when the end of track for head 39 produces a carry out of the tens stage. The second is when the system asks to stop, which takes effect at the close of the current record area. It ends unusually when the first address verify fails, or when the start head lies outside the cylinder. The head address is presented as a units digit in BCD and a binary tens digit, matching the split counter inside.

Top module: `cyl_head_stepper`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, head_o, head_sel_o, normal_end_o, unusual_end_o and compare_true_o are all zero.
- R2: A start_i pulse while idle with start_head_i (binary) at 39 or below loads head_o in the next cycle. The encoding is head_o[5:4] = start_head_i / 10 (binary tens, so bit 5 is set for heads 20 to 39) and head_o[3:0] = start_head_i % 10 (BCD). head_o[3:0] never exceeds 9.
- R3: A start_i pulse while idle with start_head_i above 39 gives a one-cycle unusual_end_o in the next cycle. It gives no head select, and the block stays idle.
- R4: head_sel_o is a one-cycle pulse. It appears in the cycle after one in which the block awaits a head select and unit_sel_i and squelch_i are both high. At no other time is it high.
- R5: After the first head select, a verify_done_i with verify_ok_i high sets compare_true_o in the next cycle. compare_true_o stays high until the operation ends and is low in the cycle its end pulse appears.
- R6: After the first head select, a verify_done_i with verify_ok_i low gives a one-cycle unusual_end_o in the next cycle. compare_true_o stays low and the block goes idle.
- R7: Only the first track is verified. After any later head select, verify_done_i and verify_ok_i have no effect: no unusual_end_o, and compare_true_o stays high.
- R8: In transfer, an eot_i on a head below 39 advances head_o by one in the next cycle, with a BCD units carry from 9 into the tens digit. The block then waits for the next head select.
- R9: An eot_i in transfer on head 39 gives a one-cycle normal_end_o in the next cycle. head_o stays 39 and the block goes idle. normal_end_o and unusual_end_o are never high together.
- R10: A sys_stop_i seen during an operation, on or before a cycle with area_end_i in transfer, gives normal_end_o in the next cycle. area_end_i with no stop pending has no effect.
- R11: When eot_i and area_end_i arrive together in transfer with a stop pending, the stop wins: normal_end_o is raised and head_o does not advance.
- R12: start_i during an operation is ignored, and head_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (pulse) |
| start_head_i | input | 6 | Starting head, binary |
| unit_sel_i | input | 1 | Access unit selected |
| squelch_i | input | 1 | Amplifier squelch conditions met |
| verify_done_i | input | 1 | Address verify finished (pulse) |
| verify_ok_i | input | 1 | Address verify result, valid with verify_done_i |
| eot_i | input | 1 | End of track (pulse) |
| sys_stop_i | input | 1 | System stop request (pulse) |
| area_end_i | input | 1 | End of current record area (pulse) |
| head_o | output | 6 | Head address: [5:4] binary tens, [3:0] BCD units |
| head_sel_o | output | 1 | Head-select strobe |
| normal_end_o | output | 1 | Normal end pulse |
| unusual_end_o | output | 1 | Unusual end pulse |
| compare_true_o | output | 1 | First-track address verified, held for the operation |

## Verification
The hardest case to reach is the carry out of head 39. It needs a full pass from a low start head through every track, each with its own select and end of track. Every tens boundary has to be crossed on the way without a stray stop. The stimulus drives complete operations from heads 0 and 37, as well as from random start heads with random stop points. The stray-input probes are issued between the steps of a track: select without unit-select, verify pulses on later tracks, area end without a stop, and restart attempts. This lets the ignored cases be seen at the outputs while the operation is still running.

// File: rtl/cyl_head_pkg.sv
package cyl_head_pkg;
  localparam int UNITS_W = 4;
  localparam logic [UNITS_W-1:0] UNITS_MAX = 4'd9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SELECT,
    ST_VERIFY,
    ST_XFER
  } seq_state_e;
endpackage

// File: rtl/head_start_decode.sv
module head_start_decode
  import cyl_head_pkg::*;
#(
  parameter int TENS_W  = 2,
  parameter int START_W = 6
) (
  input  logic [START_W-1:0] start_head_i,
  output logic [UNITS_W-1:0] units_o,
  output logic [TENS_W-1:0]  tens_o,
  output logic               valid_o
);
  localparam int NUM_HEADS = 10 * (2 ** TENS_W);

  logic [START_W-1:0] quot, rem;

  always_comb begin
    quot    = start_head_i / START_W'(10);
    rem     = start_head_i % START_W'(10);
    valid_o = (32'(start_head_i) < NUM_HEADS);
    units_o = rem[UNITS_W-1:0];
    tens_o  = quot[TENS_W-1:0];
  end
endmodule

// File: rtl/head_counter.sv
module head_counter
  import cyl_head_pkg::*;
#(
  parameter int TENS_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [UNITS_W-1:0] load_units_i,
  input  logic [TENS_W-1:0]  load_tens_i,
  input  logic               inc_i,
  output logic [UNITS_W-1:0] units_o,
  output logic [TENS_W-1:0]  tens_o,
  output logic               last_o
);
  logic units_carry;

  assign units_carry = (units_o == UNITS_MAX);
  // carry out of the top tens stage would overflow: this is the last head
  assign last_o = units_carry && (&tens_o);

  // BCD units digit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      units_o <= '0;
    else if (load_i)  units_o <= load_units_i;
    else if (inc_i)   units_o <= units_carry ? '0 : units_o + 1'b1;
  end

  // binary tens digit, preset on load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     tens_o <= '0;
    else if (load_i)                 tens_o <= load_tens_i;
    else if (inc_i && units_carry)   tens_o <= tens_o + 1'b1;
  end
endmodule

// File: rtl/head_op_sequencer.sv
module head_op_sequencer
  import cyl_head_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic start_valid_i,
  input  logic unit_sel_i,
  input  logic squelch_i,
  input  logic verify_done_i,
  input  logic verify_ok_i,
  input  logic eot_i,
  input  logic sys_stop_i,
  input  logic area_end_i,
  input  logic last_head_i,
  output logic load_o,
  output logic inc_o,
  output logic head_sel_o,
  output logic normal_end_o,
  output logic unusual_end_o,
  output logic compare_true_o
);
  seq_state_e state_q, state_d;
  logic stop_q, stop_d;
  logic cmp_d;
  logic sel_d, nend_d, uend_d;
  logic stop_seen;

  assign stop_seen = stop_q || sys_stop_i;

  always_comb begin
    state_d = state_q;
    stop_d  = stop_q;
    cmp_d   = compare_true_o;
    sel_d   = 1'b0;
    nend_d  = 1'b0;
    uend_d  = 1'b0;
    load_o  = 1'b0;
    inc_o   = 1'b0;
    if (state_q != ST_IDLE && sys_stop_i) stop_d = 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (start_valid_i) begin
            load_o  = 1'b1;
            stop_d  = 1'b0;
            cmp_d   = 1'b0;
            state_d = ST_SELECT;
          end else begin
            uend_d = 1'b1;
          end
        end
      end
      ST_SELECT: begin
        if (unit_sel_i && squelch_i) begin
          sel_d   = 1'b1;
          // compare-true blocks any further verify cycle
          state_d = compare_true_o ? ST_XFER : ST_VERIFY;
        end
      end
      ST_VERIFY: begin
        if (verify_done_i) begin
          if (verify_ok_i) begin
            cmp_d   = 1'b1;
            state_d = ST_XFER;
          end else begin
            uend_d  = 1'b1;
            stop_d  = 1'b0;
            state_d = ST_IDLE;
          end
        end
      end
      ST_XFER: begin
        if (stop_seen && area_end_i) begin
          nend_d  = 1'b1;
          cmp_d   = 1'b0;
          stop_d  = 1'b0;
          state_d = ST_IDLE;
        end else if (eot_i) begin
          if (last_head_i) begin
            nend_d  = 1'b1;
            cmp_d   = 1'b0;
            stop_d  = 1'b0;
            state_d = ST_IDLE;
          end else begin
            inc_o   = 1'b1;
            state_d = ST_SELECT;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      stop_q         <= 1'b0;
      compare_true_o <= 1'b0;
      head_sel_o     <= 1'b0;
      normal_end_o   <= 1'b0;
      unusual_end_o  <= 1'b0;
    end else begin
      state_q        <= state_d;
      stop_q         <= stop_d;
      compare_true_o <= cmp_d;
      head_sel_o     <= sel_d;
      normal_end_o   <= nend_d;
      unusual_end_o  <= uend_d;
    end
  end
endmodule

// File: rtl/cyl_head_stepper.sv
module cyl_head_stepper
  import cyl_head_pkg::*;
#(
  parameter int  TENS_W    = 2,
  localparam int NUM_HEADS = 10 * (2 ** TENS_W),
  localparam int START_W   = $clog2(NUM_HEADS),
  localparam int HEAD_W    = TENS_W + UNITS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [START_W-1:0] start_head_i,
  input  logic               unit_sel_i,
  input  logic               squelch_i,
  input  logic               verify_done_i,
  input  logic               verify_ok_i,
  input  logic               eot_i,
  input  logic               sys_stop_i,
  input  logic               area_end_i,
  output logic [HEAD_W-1:0]  head_o,
  output logic               head_sel_o,
  output logic               normal_end_o,
  output logic               unusual_end_o,
  output logic               compare_true_o
);
  logic [UNITS_W-1:0] ld_units, cnt_units;
  logic [TENS_W-1:0]  ld_tens, cnt_tens;
  logic               start_valid, load, inc, last_head;

  head_start_decode #(.TENS_W(TENS_W), .START_W(START_W)) i_decode (
    .start_head_i (start_head_i),
    .units_o      (ld_units),
    .tens_o       (ld_tens),
    .valid_o      (start_valid)
  );

  head_counter #(.TENS_W(TENS_W)) i_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .load_units_i (ld_units),
    .load_tens_i  (ld_tens),
    .inc_i        (inc),
    .units_o      (cnt_units),
    .tens_o       (cnt_tens),
    .last_o       (last_head)
  );

  head_op_sequencer i_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .start_valid_i  (start_valid),
    .unit_sel_i     (unit_sel_i),
    .squelch_i      (squelch_i),
    .verify_done_i  (verify_done_i),
    .verify_ok_i    (verify_ok_i),
    .eot_i          (eot_i),
    .sys_stop_i     (sys_stop_i),
    .area_end_i     (area_end_i),
    .last_head_i    (last_head),
    .load_o         (load),
    .inc_o          (inc),
    .head_sel_o     (head_sel_o),
    .normal_end_o   (normal_end_o),
    .unusual_end_o  (unusual_end_o),
    .compare_true_o (compare_true_o)
  );

  assign head_o = {cnt_tens, cnt_units};
endmodule

// File: rtl/cyl_head_stepper_chk.sv
module cyl_head_stepper_chk #(
  parameter int TENS_W = 2,
  parameter int START_W = 6,
  parameter int HEAD_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [START_W-1:0] start_head_i,
  input logic               unit_sel_i,
  input logic               squelch_i,
  input logic               verify_done_i,
  input logic               verify_ok_i,
  input logic               eot_i,
  input logic               sys_stop_i,
  input logic               area_end_i,
  input logic [HEAD_W-1:0]  head_o,
  input logic               head_sel_o,
  input logic               normal_end_o,
  input logic               unusual_end_o,
  input logic               compare_true_o
);
  // R2
  units_bcd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_o[3:0] <= 4'd9);

  // R4
  head_sel_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_sel_o |-> $past(unit_sel_i && squelch_i));

  // R5
  cmp_set_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(compare_true_o) |-> $past(verify_done_i && verify_ok_i));

  // R6
  unusual_no_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unusual_end_o |-> !compare_true_o);

  // R8
  head_move_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(head_o) |-> $past(start_i || eot_i));

  // R9
  end_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(normal_end_o && unusual_end_o));

  // R9
  normal_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    normal_end_o |=> !normal_end_o);
endmodule

bind cyl_head_stepper cyl_head_stepper_chk #(
  .TENS_W(TENS_W), .START_W(START_W), .HEAD_W(HEAD_W)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .start_head_i   (start_head_i),
  .unit_sel_i     (unit_sel_i),
  .squelch_i      (squelch_i),
  .verify_done_i  (verify_done_i),
  .verify_ok_i    (verify_ok_i),
  .eot_i          (eot_i),
  .sys_stop_i     (sys_stop_i),
  .area_end_i     (area_end_i),
  .head_o         (head_o),
  .head_sel_o     (head_sel_o),
  .normal_end_o   (normal_end_o),
  .unusual_end_o  (unusual_end_o),
  .compare_true_o (compare_true_o)
);

// File: tb/test_cyl_head_stepper.sv
module test_cyl_head_stepper;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [5:0] start_head_i = '0;
  logic       unit_sel_i = 1'b0;
  logic       squelch_i = 1'b0;
  logic       verify_done_i = 1'b0;
  logic       verify_ok_i = 1'b0;
  logic       eot_i = 1'b0;
  logic       sys_stop_i = 1'b0;
  logic       area_end_i = 1'b0;
  logic [5:0] head_o;
  logic       head_sel_o, normal_end_o, unusual_end_o, compare_true_o;

  int checks = 0;
  int failures = 0;

  cyl_head_stepper i_cyl_head_stepper (
    .clk_i, .rst_ni, .start_i, .start_head_i, .unit_sel_i, .squelch_i,
    .verify_done_i, .verify_ok_i, .eot_i, .sys_stop_i, .area_end_i,
    .head_o, .head_sel_o, .normal_end_o, .unusual_end_o, .compare_true_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [5:0] enc(int h);
    return {2'(h / 10), 4'(h % 10)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic run_op(int start, bit ok, int stop_track, bit probes);
    int h = start;
    bit first = 1'b1;
    int t = 0;
    start_head_i = 6'(start); start_i = 1'b1; step(); start_i = 1'b0;
    if (start > 39) begin
      chk(unusual_end_o == 1'b1, "R3 reject unusual", unusual_end_o, 1);
      chk(compare_true_o == 1'b0, "R3 reject no compare", compare_true_o, 0);
      step();
      chk(head_sel_o == 1'b0 && unusual_end_o == 1'b0, "R3 pulse/no select",
          {head_sel_o, unusual_end_o}, 0);
      return;
    end
    chk(head_o == enc(start), "R2 load", head_o, enc(start));
    forever begin
      if (probes) begin
        squelch_i = 1'b1; step(); squelch_i = 1'b0;
        chk(head_sel_o == 1'b0, "R4 squelch alone", head_sel_o, 0);
      end
      unit_sel_i = 1'b1; squelch_i = 1'b1; step();
      unit_sel_i = 1'b0; squelch_i = 1'b0;
      chk(head_sel_o == 1'b1, "R4 select strobe", head_sel_o, 1);
      verify_done_i = 1'b1; verify_ok_i = first ? ok : 1'b0; step();
      verify_done_i = 1'b0; verify_ok_i = 1'b0;
      chk(head_sel_o == 1'b0, "R4 strobe one cycle", head_sel_o, 0);
      if (first) begin
        if (!ok) begin
          chk(unusual_end_o == 1'b1, "R6 verify fail", unusual_end_o, 1);
          chk(compare_true_o == 1'b0, "R6 compare low", compare_true_o, 0);
          return;
        end
        chk(compare_true_o == 1'b1, "R5 compare set", compare_true_o, 1);
      end else begin
        chk(unusual_end_o == 1'b0, "R7 later verify ignored", unusual_end_o, 0);
        chk(compare_true_o == 1'b1, "R7 compare held", compare_true_o, 1);
      end
      first = 1'b0;
      if (probes) begin
        area_end_i = 1'b1; step(); area_end_i = 1'b0;
        chk(normal_end_o == 1'b0, "R10 area end no stop", normal_end_o, 0);
        unit_sel_i = 1'b1; squelch_i = 1'b1;
        start_head_i = 6'((h + 7) % 40); start_i = 1'b1; step();
        start_i = 1'b0; unit_sel_i = 1'b0; squelch_i = 1'b0;
        chk(head_o == enc(h), "R12 restart ignored", head_o, enc(h));
        chk(head_sel_o == 1'b0, "R4 no strobe in transfer", head_sel_o, 0);
      end
      if (t == stop_track) begin
        sys_stop_i = 1'b1; step(); sys_stop_i = 1'b0;
        chk(normal_end_o == 1'b0, "R10 stop waits for area end", normal_end_o, 0);
        area_end_i = 1'b1; step(); area_end_i = 1'b0;
        chk(normal_end_o == 1'b1, "R10 stop end", normal_end_o, 1);
        chk(compare_true_o == 1'b0, "R5 compare cleared", compare_true_o, 0);
        return;
      end
      eot_i = 1'b1; step(); eot_i = 1'b0;
      if (h == 39) begin
        chk(normal_end_o == 1'b1, "R9 last head end", normal_end_o, 1);
        chk(compare_true_o == 1'b0, "R9 compare cleared", compare_true_o, 0);
        chk(head_o == enc(39), "R9 head held", head_o, enc(39));
        step();
        chk(normal_end_o == 1'b0, "R9 end one cycle", normal_end_o, 0);
        return;
      end
      chk(head_o == enc(h + 1), "R8 step", head_o, enc(h + 1));
      chk(normal_end_o == 1'b0, "R8 no end", normal_end_o, 0);
      h++;
      t++;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) step();
    // R1
    chk({head_o, head_sel_o, normal_end_o, unusual_end_o, compare_true_o} == '0,
        "R1 in reset", head_o, 0);
    rst_ni = 1'b1;
    step();
    chk({head_o, head_sel_o, normal_end_o, unusual_end_o, compare_true_o} == '0,
        "R1 after reset", head_o, 0);

    run_op(0, 1'b1, -1, 1'b1);
    step();
    run_op(37, 1'b1, -1, 1'b1);
    step();
    run_op(40, 1'b1, -1, 1'b0);
    run_op(63, 1'b1, -1, 1'b0);
    run_op(12, 1'b0, -1, 1'b0);
    step();
    run_op(19, 1'b1, 3, 1'b1);
    step();

    // R11: stop pending, eot and area end together
    start_head_i = 6'd5; start_i = 1'b1; step(); start_i = 1'b0;
    unit_sel_i = 1'b1; squelch_i = 1'b1; step(); unit_sel_i = 1'b0; squelch_i = 1'b0;
    verify_done_i = 1'b1; verify_ok_i = 1'b1; step(); verify_done_i = 1'b0; verify_ok_i = 1'b0;
    sys_stop_i = 1'b1; step(); sys_stop_i = 1'b0;
    eot_i = 1'b1; area_end_i = 1'b1; step(); eot_i = 1'b0; area_end_i = 1'b0;
    chk(normal_end_o == 1'b1, "R11 stop wins", normal_end_o, 1);
    chk(head_o == enc(5), "R11 no advance", head_o, enc(5));
    step();

    for (int i = 0; i < 25; i++) begin
      int s = $urandom_range(44, 0);
      bit v = ($urandom_range(9, 0) != 0);
      int st = ($urandom_range(3, 0) == 0) ? -1 : int'($urandom_range(12, 0));
      bit p = 1'($urandom_range(1, 0));
      run_op(s, v, st, p);
      step();
    end
    summary();
  end
endmodule